// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. The host offers a byte with a valid/ready handshake; an external baud divider supplies a one-cycle tick at sixteen times the bit rate. The frame shape is set per character by a handful of control inputs: character width (5 to 8 bits), whether a parity bit follows and how it is formed (odd, even, or forced to a fixed level), and whether one or two stop periods close the frame. For 5-bit characters the long stop setting yields one and a half stop periods.

A separate break input drives the line to the spacing level for as long as it is held. It overrides only the output pin: a frame already under way keeps running on its own timing underneath, and the line goes back to normal levels when break is released. The control inputs are captured at the moment a character is accepted, so the host may change them while a frame is still being sent.

Top module: `uart_frame_tx`

## Requirements
- R1: Out of reset, and at any time with no frame under way and break low, `txd` is 1, `busy` is 0 and `in_ready` is 1. A reset in the middle of a frame abandons it.
- R2: A character is taken on a clock edge where `in_valid` and `in_ready` are both 1; `busy` is 1 and `in_ready` is 0 from the next cycle until the frame is over, and offers made meanwhile are ignored.
- R3: A frame begins with a start bit at 0 and sends its data bits least significant first. Each bit lasts 16 ticks, and `txd` changes one clock after the tick edge that ends the previous bit.
- R4: `cfg_wlen` gives the character width: 0 is 5 bits, 1 is 6, 2 is 7, 3 is 8. Bits of `in_data` above the width are neither sent nor counted in parity.
- R5: With `cfg_par_en` at 0 no parity bit is sent, whatever `cfg_par_even` and `cfg_par_sticky` hold.
- R6: With `cfg_par_en` 1 and `cfg_par_sticky` 0, a parity bit follows the data: `cfg_par_even` 0 makes the count of ones over data plus parity odd, and 1 makes it even.
- R7: With `cfg_par_en` 1 and `cfg_par_sticky` 1, the parity bit is 1 when `cfg_par_even` is 0 and 0 when it is 1.
- R8: The stop period at level 1 lasts 16 ticks when `cfg_two_stop` is 0; with it at 1 it lasts 32 ticks, or 24 ticks for 5-bit characters.
- R9: `busy` falls on the tick edge that ends the stop period and on no other edge; the line then stays at 1.
- R10: While `brk` is 1, `txd` is 0 from the next clock on; a frame under way keeps its timing and ends on the same tick as without break, and `txd` returns to its normal level one clock after `brk` falls.
- R11: The control inputs are sampled on the accepting edge; changes to them during a frame do not alter it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | One-cycle pulse at 16 times the bit rate |
| in_valid | input | 1 | Character offered |
| in_ready | output | 1 | Block can accept a character |
| in_data | input | 8 | Character, sent from bit 0 up |
| cfg_wlen | input | 2 | Character width code (0..3 for 5..8 bits) |
| cfg_par_en | input | 1 | Parity bit present |
| cfg_par_even | input | 1 | Even parity, or forced 0 when sticky |
| cfg_par_sticky | input | 1 | Parity forced to a fixed level |
| cfg_two_stop | input | 1 | Long stop period (two, or one and a half for 5 bits) |
| brk | input | 1 | Hold the line at 0 |
| txd | output | 1 | Serial output, idles at 1 |
| busy | output | 1 | Frame in progress |

## Verification
The frame engine is driven through a table of characters that walks every width code, all five parity settings and both stop settings, so that a fault in width decode, parity sense, forced-level polarity or stop length each moves a different tick of the captured line. Data values with ones above the chosen width separate correct masking from parity over the whole byte. Further frames run with break asserted across part of the frame, with control inputs and a competing offer toggled mid-frame, and with reset striking mid-frame; these show that break touches only the pin, that the captured format is held, and that a frame can be abandoned cleanly.

// File: rtl/uftx_pkg.sv
package uftx_pkg;

  localparam int CHAR_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_START  = 3'd1,
    ST_DATA   = 3'd2,
    ST_PARITY = 3'd3,
    ST_STOP   = 3'd4
  } tx_state_e;

  typedef struct packed {
    logic [1:0] wlen;
    logic       par_en;
    logic       par_even;
    logic       par_sticky;
    logic       two_stop;
  } frame_cfg_t;

  // index of the last data bit sent: 4 for 5-bit characters up to 7
  function automatic logic [2:0] last_data_index(logic [1:0] wlen);
    return 3'd4 + {1'b0, wlen};
  endfunction

  // mask covering the data bits in use
  function automatic logic [CHAR_W-1:0] width_mask(logic [1:0] wlen);
    return {CHAR_W{1'b1}} >> (2'd3 - wlen);
  endfunction

  // level of the parity bit for a character under a given format
  function automatic logic parity_level(logic [CHAR_W-1:0] data, frame_cfg_t c);
    logic odd_ones;
    odd_ones = ^(data & width_mask(c.wlen));
    if (c.par_sticky) return ~c.par_even;
    return c.par_even ? odd_ones : ~odd_ones;
  endfunction

  // length of the stop period in half bits: 2, 3 or 4
  function automatic int unsigned stop_halves(frame_cfg_t c);
    if (!c.two_stop) return 2;
    if (c.wlen == 2'd0) return 3;
    return 4;
  endfunction

  // line level a state asks for, break aside
  function automatic logic state_level(tx_state_e st, logic data_bit, logic par_bit);
    case (st)
      ST_START:  return 1'b0;
      ST_DATA:   return data_bit;
      ST_PARITY: return par_bit;
      default:   return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/uftx_payload.sv
module uftx_payload
  import uftx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift_en,
  input  logic [CHAR_W-1:0] load_data,
  input  frame_cfg_t        load_cfg,
  output frame_cfg_t        cfg_q,
  output logic              data_bit,
  output logic              par_bit
);

  logic [CHAR_W-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      par_bit <= 1'b0;
      cfg_q   <= '0;
    end else if (load) begin
      shreg   <= load_data;
      par_bit <= parity_level(load_data, load_cfg);
      cfg_q   <= load_cfg;
    end else if (shift_en) begin
      shreg   <= {1'b0, shreg[CHAR_W-1:1]};
    end
  end

  assign data_bit = shreg[0];

endmodule

// File: rtl/uftx_seq.sv
module uftx_seq
  import uftx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       load,
  input  frame_cfg_t cfg_q,
  output tx_state_e  state,
  output logic [2:0] bit_idx,
  output logic       shift_en,
  output logic       frame_end
);

  localparam int HALF  = OVERSAMPLE / 2;
  localparam int CNT_W = $clog2(2 * OVERSAMPLE);

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] stop_last;
  logic             bit_last;
  logic             phase_end;
  logic             data_last;
  tx_state_e        state_nx;

  assign stop_last = CNT_W'(stop_halves(cfg_q) * HALF - 1);
  assign bit_last  = (cnt == CNT_W'(OVERSAMPLE - 1));
  assign data_last = (bit_idx == last_data_index(cfg_q.wlen));
  assign phase_end = tick && (state != ST_IDLE) &&
                     ((state == ST_STOP) ? (cnt == stop_last) : bit_last);
  assign shift_en  = phase_end && (state == ST_DATA);
  assign frame_end = phase_end && (state == ST_STOP);

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE:   if (load) state_nx = ST_START;
      ST_START:  if (phase_end) state_nx = ST_DATA;
      ST_DATA:   if (phase_end && data_last)
                   state_nx = cfg_q.par_en ? ST_PARITY : ST_STOP;
      ST_PARITY: if (phase_end) state_nx = ST_STOP;
      ST_STOP:   if (phase_end) state_nx = ST_IDLE;
      default:   state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bit_idx <= '0;
    end else begin
      state <= state_nx;
      if (load || phase_end) cnt <= '0;
      else if (tick && state != ST_IDLE) cnt <= cnt + 1'b1;
      if (load || (phase_end && state == ST_START)) bit_idx <= '0;
      else if (shift_en && !data_last) bit_idx <= bit_idx + 1'b1;
    end
  end

endmodule

// File: rtl/uftx_line.sv
module uftx_line
  import uftx_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  tx_state_e state,
  input  logic      data_bit,
  input  logic      par_bit,
  input  logic      brk,
  output logic      txd
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) txd <= 1'b1;
    else if (brk) txd <= 1'b0;
    else txd <= state_level(state, data_bit, par_bit);
  end

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
  import uftx_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic [1:0] cfg_wlen,
  input  logic       cfg_par_en,
  input  logic       cfg_par_even,
  input  logic       cfg_par_sticky,
  input  logic       cfg_two_stop,
  input  logic       brk,
  output logic       txd,
  output logic       busy
);

  tx_state_e  state;
  frame_cfg_t cfg_in;
  frame_cfg_t cfg_q;
  logic       accept;
  logic       shift_en;
  logic       frame_end;
  logic       data_bit;
  logic       par_bit;
  logic [2:0] bit_idx;

  assign cfg_in   = '{wlen: cfg_wlen, par_en: cfg_par_en, par_even: cfg_par_even,
                      par_sticky: cfg_par_sticky, two_stop: cfg_two_stop};
  assign in_ready = (state == ST_IDLE);
  assign accept   = in_valid && in_ready;
  assign busy     = (state != ST_IDLE);

  uftx_payload i_payload (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .shift_en (shift_en),
    .load_data(in_data),
    .load_cfg (cfg_in),
    .cfg_q    (cfg_q),
    .data_bit (data_bit),
    .par_bit  (par_bit)
  );

  uftx_seq #(.OVERSAMPLE(OVERSAMPLE)) i_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .load     (accept),
    .cfg_q    (cfg_q),
    .state    (state),
    .bit_idx  (bit_idx),
    .shift_en (shift_en),
    .frame_end(frame_end)
  );

  uftx_line i_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .state   (state),
    .data_bit(data_bit),
    .par_bit (par_bit),
    .brk     (brk),
    .txd     (txd)
  );

endmodule

// File: rtl/uftx_chk.sv
module uftx_chk
  import uftx_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       accept,
  input logic       brk,
  input logic       busy,
  input logic       txd,
  input logic       frame_end,
  input tx_state_e  state,
  input logic [2:0] bit_idx,
  input frame_cfg_t cfg_q
);

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  // R9
  busy_tick_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> busy);

  // R9
  end_goes_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> !busy);

  // R10
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk |=> !txd);

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !brk) |=> txd);

  // R3
  start_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |=> !txd);

  // R11
  cfg_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(cfg_q));

  // R4
  data_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DATA) |-> (bit_idx <= last_data_index(cfg_q.wlen)));

endmodule

bind uart_frame_tx uftx_chk i_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .tick     (tick),
  .accept   (accept),
  .brk      (brk),
  .busy     (busy),
  .txd      (txd),
  .frame_end(frame_end),
  .state    (state),
  .bit_idx  (bit_idx),
  .cfg_q    (cfg_q)
);

// File: tb/test_uart_frame_tx.sv
module test_uart_frame_tx;

  typedef struct packed {
    logic [7:0] data;
    logic [1:0] wlen;
    logic       pen;
    logic       even;
    logic       sticky;
    logic       two;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{8'hA5, 2'd3, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'hA5, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0},
    '{8'hA5, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0},
    '{8'h3C, 2'd2, 1'b1, 1'b0, 1'b1, 1'b0},
    '{8'h3C, 2'd2, 1'b1, 1'b1, 1'b1, 1'b1},
    '{8'hFF, 2'd0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{8'hFF, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0},
    '{8'h2B, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1},
    '{8'h00, 2'd3, 1'b1, 1'b0, 1'b0, 1'b1},
    '{8'h80, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0},
    '{8'hE0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b1}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_data = 8'h00;
  logic [1:0] cfg_wlen = 2'd0;
  logic       cfg_par_en = 1'b0;
  logic       cfg_par_even = 1'b0;
  logic       cfg_par_sticky = 1'b0;
  logic       cfg_two_stop = 1'b0;
  logic       brk = 1'b0;
  logic       txd;
  logic       busy;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_frame_tx i_uart_frame_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en),
    .cfg_par_even(cfg_par_even), .cfg_par_sticky(cfg_par_sticky),
    .cfg_two_stop(cfg_two_stop), .brk(brk), .txd(txd), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int nbits(vec_t v);
    return 5 + int'(v.wlen);
  endfunction

  function automatic int frame_slots(vec_t v);
    int stop;
    if (!v.two) stop = 16;
    else if (nbits(v) == 5) stop = 24;
    else stop = 32;
    return 16 * (1 + nbits(v) + int'(v.pen)) + stop;
  endfunction

  function automatic logic exp_level(vec_t v, int s);
    int n;
    int ones;
    int idx;
    logic par;
    n = nbits(v);
    ones = 0;
    for (int i = 0; i < n; i++) ones += int'(v.data[i]);
    if (v.sticky) par = !v.even;
    else if (v.even) par = (ones % 2 == 1);
    else par = (ones % 2 == 0);
    idx = s / 16;
    if (idx == 0) return 1'b0;
    if (idx <= n) return v.data[idx-1];
    if (v.pen && idx == n + 1) return par;
    return 1'b1;
  endfunction

  // one frame; break held over slots [bf, bt); noise toggles inputs mid-frame
  task automatic run_frame(input vec_t v, input int bf, input int bt, input bit noise,
                           input string tag);
    int total;
    int bad_slot;
    int bad_act;
    int bad_exp;
    bit len_ok;
    logic e;
    total = frame_slots(v);
    bad_slot = -1;
    bad_act = 0;
    bad_exp = 0;
    len_ok = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1 && busy === 1'b0, {"R2 ready before offer ", tag},
          int'(in_ready), 1);
    in_data = v.data; cfg_wlen = v.wlen; cfg_par_en = v.pen; cfg_par_even = v.even;
    cfg_par_sticky = v.sticky; cfg_two_stop = v.two; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(busy === 1'b1 && in_ready === 1'b0, {"R2 busy after accept ", tag},
          int'(busy), 1);
    if (noise) begin
      in_valid = 1'b1; in_data = ~v.data; cfg_wlen = ~v.wlen; cfg_par_en = ~v.pen;
      cfg_par_even = ~v.even; cfg_par_sticky = ~v.sticky; cfg_two_stop = ~v.two;
    end
    for (int s = 0; s < total; s++) begin
      brk = (s >= bf && s < bt);
      if (s == total - 2) in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      @(negedge clk);
      tick = 1'b1;
      e = (s >= bf && s < bt) ? 1'b0 : exp_level(v, s);
      if (txd !== e && bad_slot < 0) begin
        bad_slot = s; bad_act = int'(txd); bad_exp = int'(e);
      end
      if (busy !== 1'b1) len_ok = 1'b0;
      @(negedge clk);
      tick = 1'b0;
    end
    brk = 1'b0;
    in_valid = 1'b0;
    if (bad_slot >= 0) $display("  %s first bad slot %0d", tag, bad_slot);
    check(bad_slot < 0, {"R3 R4 R5 R6 R7 R10 R11 line levels ", tag}, bad_act, bad_exp);
    check(len_ok && busy === 1'b0 && in_ready === 1'b1,
          {"R8 R9 frame length ", tag}, int'(busy), 0);
    @(negedge clk);
    check(txd === 1'b1, {"R9 line high after frame ", tag}, int'(txd), 1);
    for (int k = 0; k < 64 && busy; k++) begin
      tick = 1'b1; @(negedge clk); tick = 1'b0; @(negedge clk);
    end
  endtask

  initial begin
    repeat (200) @(posedge clk);
    forever begin
      @(posedge clk);
      if (done) break;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check(txd === 1'b1, "R1 txd in reset", int'(txd), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    check(in_ready === 1'b1, "R1 ready after reset", int'(in_ready), 1);
    check(txd === 1'b1, "R1 line idle high", int'(txd), 1);

    // table of frame formats
    for (int i = 0; i < NVEC; i++) run_frame(VECS[i], -1, -1, 1'b0, $sformatf("vec%0d", i));

    // R10 break while idle
    @(negedge clk);
    brk = 1'b1;
    @(negedge clk);
    check(txd === 1'b0, "R10 break idle low", int'(txd), 0);
    check(busy === 1'b0, "R10 break starts nothing", int'(busy), 0);
    brk = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R10 release restores idle", int'(txd), 1);

    // R10 break across start and data, frame timing kept
    run_frame(VECS[7], 5, 60, 1'b0, "break mid");
    // R10 break over the stop period
    run_frame(VECS[5], 100, 200, 1'b0, "break stop");
    // R2 R11 competing offer and format changes mid-frame
    run_frame(VECS[4], -1, -1, 1'b1, "noise 7bit");
    run_frame(VECS[10], -1, -1, 1'b1, "noise 5bit");

    // R1 reset mid-frame abandons it
    @(negedge clk);
    in_data = 8'h00; cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    check(txd === 1'b0, "R3 start bit low", int'(txd), 0);
    rst_n = 1'b0;
    @(negedge clk);
    check(txd === 1'b1 && busy === 1'b0, "R1 mid-frame reset", int'(txd), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R1 ready after mid-frame reset", int'(in_ready), 1);
    run_frame(VECS[0], -1, -1, 1'b0, "after reset");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule